// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This controller performs the entry half of exception handling for a 32-bit core. Each cycle it looks at three request channels: a system channel for soft reset or non-maskable interrupt, a debug channel, and a general exception channel. It also receives the faulting PC and a flag that says whether the faulting instruction sat in a branch delay slot. It picks the request with the highest priority and updates its own copy of the state that the exception architecture defines. That state is the exception level, error level and boot-vector flags, the user and debug mode flags, the cause code, the branch-delay bit and the coprocessor field, the three return-address registers and the debug reason flags. One cycle later it presents the handler address on `vec_pc` and pulses `vec_valid`.

The general handler address is a base plus an offset. The base depends on the boot-vector flag. The offset depends on whether the request is an interrupt with the vectored-interrupt mode enabled, or a TLB refill taken while the exception level is clear. System and debug entries each go to their own fixed address. An external interrupt raised while the core is in debug mode is handled as a debug interrupt. A request whose code is not recognised raises `bad_req` for one cycle and changes no state.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `user_mode` is 1 and every other flag, field, register and output is 0.
- R2: A general request with a recognised code (0 interrupt, 1 modify, 2 TLB load, 3 TLB store, 4 address error, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 23 watch, 24 machine check) writes that code into `cause_code`. On the next cycle `vec_valid` is high for exactly one cycle.
- R3: The general base address is 0x80000000 when `st_bev` is 0 and 0xBFC00200 when it is 1. The default offset is 0x180.
- R4: The offset is 0x200 for code 0 when `iv_mode` is 1. It is 0x000 for code 2 or 3 with `exc_refill` set while `st_exl` is 0. A refill taken while `st_exl` is 1 uses 0x180.
- R5: A general entry with `st_exl` at 0 writes `epc` with PC-4 and sets `cause_bd` when `in_dslot` is 1. Otherwise it writes `epc` with PC and clears `cause_bd`. It then sets `st_exl` and clears `user_mode`.
- R6: A general entry with `st_exl` already at 1 leaves `epc` and `cause_bd` unchanged.
- R7: Code 11 copies `exc_ce` into `cause_ce`. Every other code leaves `cause_ce` unchanged.
- R8: A system request sets `st_nmi` when `sys_nmi`=1 and sets `st_sr` when `sys_nmi`=0. Either kind writes `err_epc` using the delay-slot rule of R5, sets `st_erl` and `st_bev`, clears `user_mode` and vectors to 0xBFC00000. It leaves the cause fields and `epc` untouched.
- R9: A debug request of kind k (0 single step, 1 debug interrupt, 2 instruction break, 3 break instruction, 4 data break on store, 5 data break on load) sets `dbg_flags[k]`. It writes `depc` using the delay-slot rule, sets `debug_mode`, clears `user_mode` and vectors to 0xBFC00480.
- R10: A single-step debug entry (kind 0) writes `depc` with the unadjusted PC even when `in_dslot` is 1.
- R11: A general request with code 0 while `debug_mode` is 1 is handled as a debug request of kind 1. The cause fields and `epc` are left unchanged.
- R12: When several channels assert in the same cycle, the system channel wins over debug, and debug wins over general. Requests that lose are discarded.
- R13: If the winning request carries an unrecognised code (a general code outside the R2 list, or debug kind 6 or 7), `bad_req` pulses on the next cycle, `vec_valid` stays low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_req | input | 1 | System request (soft reset or NMI) |
| sys_nmi | input | 1 | 1 selects NMI, 0 selects soft reset |
| dbg_req | input | 1 | Debug request |
| dbg_kind | input | 3 | Debug reason, see R9 |
| exc_req | input | 1 | General exception request |
| exc_code | input | 5 | General cause code, see R2 |
| exc_ce | input | 2 | Coprocessor number for code 11 |
| exc_refill | input | 1 | TLB access missed (refill case) |
| iv_mode | input | 1 | Vectored interrupt mode enable |
| pc | input | 32 | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction is in a delay slot |
| vec_valid | output | 1 | One-cycle pulse: `vec_pc` is the new PC |
| vec_pc | output | 32 | Handler address |
| bad_req | output | 1 | One-cycle pulse: winning request code unknown |
| st_exl | output | 1 | Exception level |
| st_erl | output | 1 | Error level |
| st_bev | output | 1 | Boot exception vectors |
| st_nmi | output | 1 | NMI occurred |
| st_sr | output | 1 | Soft reset occurred |
| user_mode | output | 1 | Core is in user mode |
| debug_mode | output | 1 | Core is in debug mode |
| cause_code | output | 5 | Last general cause code |
| cause_bd | output | 1 | Last general entry came from a delay slot |
| cause_ce | output | 2 | Coprocessor number of last unusable fault |
| epc | output | 32 | General return address |
| err_epc | output | 32 | Error return address |
| depc | output | 32 | Debug return address |
| dbg_flags | output | 6 | Debug reason flags, bit index = kind |

## Verification
The collisions of interest arise when channels assert in the same cycle. A debug or system request can arrive together with a general exception, and an external interrupt can arrive after debug mode has been entered, which pushes a general code onto the debug path. The bench provokes these directly. It also draws random combinations of all three channels with random codes, kinds, PCs and delay-slot flags, and it resets at intervals so that both values of the exception level are exercised. After every request it compares every output against a bench-side model of the priority and entry rules: the handler address, both pulses, every flag and all three return addresses.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int          AW        = 32,
  parameter int          NDBG      = 6,
  parameter logic [31:0] GEN_BASE  = 32'h8000_0000,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] SYS_VEC   = 32'hBFC0_0000,
  parameter logic [31:0] DBG_VEC   = 32'hBFC0_0480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_req,
  input  logic          sys_nmi,
  input  logic          dbg_req,
  input  logic [2:0]    dbg_kind,
  input  logic          exc_req,
  input  logic [4:0]    exc_code,
  input  logic [1:0]    exc_ce,
  input  logic          exc_refill,
  input  logic          iv_mode,
  input  logic [AW-1:0] pc,
  input  logic          in_dslot,
  output logic          vec_valid,
  output logic [AW-1:0] vec_pc,
  output logic          bad_req,
  output logic          st_exl,
  output logic          st_erl,
  output logic          st_bev,
  output logic          st_nmi,
  output logic          st_sr,
  output logic          user_mode,
  output logic          debug_mode,
  output logic [4:0]    cause_code,
  output logic          cause_bd,
  output logic [1:0]    cause_ce,
  output logic [AW-1:0] epc,
  output logic [AW-1:0] err_epc,
  output logic [AW-1:0] depc,
  output logic [NDBG-1:0] dbg_flags
);

  localparam logic [AW-1:0] OFS_DEF = AW'(12'h180);
  localparam logic [AW-1:0] OFS_INT = AW'(12'h200);

  function automatic logic code_known(input logic [4:0] c);
    case (c)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd7, 5'd8, 5'd9,
      5'd10, 5'd11, 5'd12, 5'd13, 5'd23, 5'd24: code_known = 1'b1;
      default: code_known = 1'b0;
    endcase
  endfunction

  wire       ext_to_dbg = exc_req && exc_code == 5'd0 && debug_mode;
  wire       take_sys   = sys_req;
  wire       take_dbg   = !sys_req && (dbg_req || ext_to_dbg);
  wire       take_exc   = !sys_req && !take_dbg && exc_req;
  wire [2:0] dkind      = dbg_req ? dbg_kind : 3'd1;
  wire       dbg_ok     = 32'(dkind) < NDBG;
  wire       exc_ok     = code_known(exc_code);
  wire       is_bad     = (take_dbg && !dbg_ok) || (take_exc && !exc_ok);

  wire [AW-1:0] pc_ret = in_dslot ? pc - AW'(4) : pc;

  logic [AW-1:0] gen_ofs;
  always_comb begin
    gen_ofs = OFS_DEF;
    if (exc_code == 5'd0 && iv_mode)
      gen_ofs = OFS_INT;
    else if ((exc_code == 5'd2 || exc_code == 5'd3) && exc_refill && !st_exl)
      gen_ofs = '0;
  end

  wire [AW-1:0] gen_vec = (st_bev ? BOOT_BASE[AW-1:0] : GEN_BASE[AW-1:0]) + gen_ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid  <= 1'b0;
      vec_pc     <= '0;
      bad_req    <= 1'b0;
      st_exl     <= 1'b0;
      st_erl     <= 1'b0;
      st_bev     <= 1'b0;
      st_nmi     <= 1'b0;
      st_sr      <= 1'b0;
      user_mode  <= 1'b1;
      debug_mode <= 1'b0;
      cause_code <= '0;
      cause_bd   <= 1'b0;
      cause_ce   <= '0;
      epc        <= '0;
      err_epc    <= '0;
      depc       <= '0;
      dbg_flags  <= '0;
    end else begin
      vec_valid <= 1'b0;
      bad_req   <= is_bad;
      if (take_sys) begin
        if (sys_nmi) st_nmi <= 1'b1;
        else         st_sr  <= 1'b1;
        err_epc   <= pc_ret;
        st_erl    <= 1'b1;
        st_bev    <= 1'b1;
        user_mode <= 1'b0;
        vec_pc    <= SYS_VEC[AW-1:0];
        vec_valid <= 1'b1;
      end else if (take_dbg && dbg_ok) begin
        dbg_flags[dkind] <= 1'b1;
        depc       <= (dkind == 3'd0) ? pc : pc_ret;
        debug_mode <= 1'b1;
        user_mode  <= 1'b0;
        vec_pc     <= DBG_VEC[AW-1:0];
        vec_valid  <= 1'b1;
      end else if (take_exc && exc_ok) begin
        if (!st_exl) begin
          epc       <= pc_ret;
          cause_bd  <= in_dslot;
          st_exl    <= 1'b1;
          user_mode <= 1'b0;
        end
        cause_code <= exc_code;
        if (exc_code == 5'd11) cause_ce <= exc_ce;
        vec_pc    <= gen_vec;
        vec_valid <= 1'b1;
      end
    end
  end

  // R13
  bad_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |-> !vec_valid);

  // R5
  vec_leaves_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !user_mode);

  // R6
  epc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exl && !sys_req) |=> ($stable(epc) && $stable(cause_bd)));

  // R8
  sys_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req |=> (vec_valid && vec_pc == SYS_VEC[AW-1:0] && st_erl && st_bev));

  // R9
  dbg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !sys_req && dbg_kind < 3'd6) |=> (vec_valid && debug_mode && vec_pc == DBG_VEC[AW-1:0]));

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_req = 0, sys_nmi = 0, dbg_req = 0, exc_req = 0, exc_refill = 0, iv_mode = 0, in_dslot = 0;
  logic [2:0] dbg_kind = 0;
  logic [4:0] exc_code = 0;
  logic [1:0] exc_ce = 0;
  logic [31:0] pc = 0;
  logic vec_valid, bad_req, st_exl, st_erl, st_bev, st_nmi, st_sr, user_mode, debug_mode, cause_bd;
  logic [31:0] vec_pc, epc, err_epc, depc;
  logic [4:0] cause_code;
  logic [1:0] cause_ce;
  logic [5:0] dbg_flags;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sys_req(sys_req), .sys_nmi(sys_nmi), .dbg_req(dbg_req),
    .dbg_kind(dbg_kind), .exc_req(exc_req), .exc_code(exc_code), .exc_ce(exc_ce),
    .exc_refill(exc_refill), .iv_mode(iv_mode), .pc(pc), .in_dslot(in_dslot),
    .vec_valid(vec_valid), .vec_pc(vec_pc), .bad_req(bad_req), .st_exl(st_exl),
    .st_erl(st_erl), .st_bev(st_bev), .st_nmi(st_nmi), .st_sr(st_sr), .user_mode(user_mode),
    .debug_mode(debug_mode), .cause_code(cause_code), .cause_bd(cause_bd), .cause_ce(cause_ce),
    .epc(epc), .err_epc(err_epc), .depc(depc), .dbg_flags(dbg_flags));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic m_vv, m_bad, m_exl, m_erl, m_bev, m_nmi, m_sr, m_um, m_dm, m_bd;
  logic [31:0] m_vpc, m_epc, m_eepc, m_depc;
  logic [4:0] m_code;
  logic [1:0] m_ce;
  logic [5:0] m_flags;

  function automatic bit listed(input logic [4:0] c);
    return c inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10,
                     5'd11, 5'd12, 5'd13, 5'd23, 5'd24};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "vec_valid", 32'(vec_valid), 32'(m_vv));
    if (m_vv) chk(tag, "vec_pc", vec_pc, m_vpc);
    chk(tag, "bad_req", 32'(bad_req), 32'(m_bad));
    chk(tag, "status", 32'({st_exl, st_erl, st_bev, st_nmi, st_sr, user_mode, debug_mode}),
        32'({m_exl, m_erl, m_bev, m_nmi, m_sr, m_um, m_dm}));
    chk(tag, "cause", 32'({cause_code, cause_bd, cause_ce}), 32'({m_code, m_bd, m_ce}));
    chk(tag, "epc", epc, m_epc);
    chk(tag, "err_epc", err_epc, m_eepc);
    chk(tag, "depc", depc, m_depc);
    chk(tag, "dbg_flags", 32'(dbg_flags), 32'(m_flags));
  endtask

  task automatic model_reset();
    {m_vv, m_bad, m_exl, m_erl, m_bev, m_nmi, m_sr, m_dm, m_bd} = '0;
    m_um = 1; m_vpc = 0; m_epc = 0; m_eepc = 0; m_depc = 0; m_code = 0; m_ce = 0; m_flags = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  task automatic fire(input string tag, input bit s, input bit nmi, input bit d, input logic [2:0] dk,
                      input bit e, input logic [4:0] c, input logic [1:0] ce, input bit rf,
                      input bit iv, input logic [31:0] p, input bit ds);
    logic [31:0] adj, ofs;
    logic [2:0] k;
    @(negedge clk);
    sys_req = s; sys_nmi = nmi; dbg_req = d; dbg_kind = dk; exc_req = e; exc_code = c;
    exc_ce = ce; exc_refill = rf; iv_mode = iv; pc = p; in_dslot = ds;
    adj = ds ? p - 32'd4 : p;
    m_vv = 0; m_bad = 0;
    if (s) begin
      if (nmi) m_nmi = 1; else m_sr = 1;
      m_eepc = adj; m_erl = 1; m_bev = 1; m_um = 0; m_vpc = 32'hBFC00000; m_vv = 1;
    end else if (d || (e && c == 0 && m_dm)) begin
      k = d ? dk : 3'd1;
      if (k > 3'd5) m_bad = 1;
      else begin
        m_flags[k] = 1; m_depc = (k == 0) ? p : adj; m_dm = 1; m_um = 0;
        m_vpc = 32'hBFC00480; m_vv = 1;
      end
    end else if (e) begin
      if (!listed(c)) m_bad = 1;
      else begin
        ofs = 32'h180;
        if (c == 0 && iv) ofs = 32'h200;
        else if ((c == 2 || c == 3) && rf && !m_exl) ofs = 0;
        m_vpc = (m_bev ? 32'hBFC00200 : 32'h80000000) + ofs;
        if (!m_exl) begin m_epc = adj; m_bd = ds; m_exl = 1; m_um = 0; end
        m_code = c;
        if (c == 11) m_ce = ce;
        m_vv = 1;
      end
    end
    @(negedge clk);
    sys_req = 0; dbg_req = 0; exc_req = 0;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // general entry, default offset, delay slot, then frozen EPC
    fire("R2", 0,0, 0,0, 1,5'd8,0,0,0, 32'h0000_1000, 1);
    fire("R3", 0,0, 0,0, 1,5'd12,0,0,0, 32'h0000_2000, 0);
    fire("R6", 0,0, 0,0, 1,5'd9,0,0,0, 32'h0000_3000, 0);
    fire("R4", 0,0, 0,0, 1,5'd2,0,1,0, 32'h0000_3100, 0);
    do_reset();
    fire("R4", 0,0, 0,0, 1,5'd3,0,1,0, 32'h0000_4000, 0);
    do_reset();
    fire("R4", 0,0, 0,0, 1,5'd0,0,0,1, 32'h0000_5004, 1);
    fire("R7", 0,0, 0,0, 1,5'd11,2'd3,0,0, 32'h0000_5100, 0);
    fire("R7", 0,0, 0,0, 1,5'd4,2'd1,0,0, 32'h0000_5200, 0);
    fire("R5", 0,0, 0,0, 1,5'd24,0,0,0, 32'h0000_5300, 0);
    do_reset();
    fire("R5", 0,0, 0,0, 1,5'd10,0,0,0, 32'h0000_6000, 0);
    // system entries, then BEV base
    fire("R8", 1,1, 0,0, 0,0,0,0,0, 32'h0000_7008, 1);
    fire("R8", 1,0, 0,0, 0,0,0,0,0, 32'h0000_7100, 0);
    fire("R3", 0,0, 0,0, 1,5'd13,0,0,0, 32'h0000_7200, 0);
    // debug entries
    do_reset();
    fire("R10", 0,0, 1,3'd0, 0,0,0,0,0, 32'h0000_8008, 1);
    fire("R9", 0,0, 1,3'd4, 0,0,0,0,0, 32'h0000_8108, 1);
    fire("R11", 0,0, 0,0, 1,5'd0,0,0,0, 32'h0000_8200, 0);
    fire("R13", 0,0, 1,3'd7, 0,0,0,0,0, 32'h0000_8300, 0);
    // collisions
    do_reset();
    fire("R12", 1,1, 1,3'd2, 1,5'd8,0,0,0, 32'h0000_9000, 0);
    fire("R12", 0,0, 1,3'd5, 1,5'd12,0,0,0, 32'h0000_9100, 0);
    fire("R13", 0,0, 0,0, 1,5'd5,0,0,0, 32'h0000_9200, 0);
    fire("R13", 0,0, 0,0, 1,5'd31,0,0,0, 32'h0000_9300, 0);

    for (int i = 0; i < 400; i++) begin
      if (i % 16 == 0) do_reset();
      fire("R12", ($urandom % 8) == 0, $urandom % 2, ($urandom % 5) == 0, 3'($urandom),
           ($urandom % 3) != 0, 5'($urandom % 26), 2'($urandom), $urandom % 2,
           $urandom % 2, $urandom & 32'hFFFF_FFFC, $urandom % 2);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule